// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the three-wire serial slave that gives a host access to the byte-wide configuration space of a data converter. The host lowers the chip-select line, clocks a 16-bit instruction and then one or more data bytes on the serial clock. A single data line is shared by both directions: the block takes data from it while the instruction and write data are being clocked in, and drives it for read data. All pins are brought into the system clock domain through synchronizers. Edges of the serial clock are detected there, so the serial clock must run several times slower than the system clock.

Writes to the functional settings (power mode, clock duty-cycle stabilizer, output data format) land in shadow copies that can be read back at once. The outputs of the block follow the live copies, which change only when the host writes the commit bit. A configuration byte selects LSB-first framing and triggers a soft reset. Two read-only bytes report an identifier and a speed grade. If chip-select is held low through reset, the serial port stays off and the data and clock pins act as static strap inputs.

The serial pins carry no back-pressure. The host sets the pace through the serial clock and the block keeps up with any rate of at most one serial bit per six system clocks.

Top module: `spi_cfg_port`

## Requirements
- R1: A frame begins when chip-select falls. Bits are taken from `sdio_in` on rising serial-clock edges. The first 16 bits form the instruction: bit 15 is 1 for read and 0 for write, bits 14:13 are the length code and bits 12:0 the byte address, sent MSB-first unless LSB-first is active.
- R2: A length code of 0, 1 or 2 moves exactly 1, 2 or 3 data bytes. Later serial clocks in the same frame write nothing and read nothing.
- R3: Length code 3 streams bytes until chip-select rises. After each byte the address steps down by one in MSB-first framing and up by one in LSB-first framing, also for length codes 1 and 2.
- R4: In a read frame `sdio_oe` is high and `sdio_out` changes on falling serial-clock edges, from the first falling edge after the instruction until the last requested bit. `sdio_oe` is never high in write frames or between frames.
- R5: Address 0x00 reads 0x18 after reset. Writing 1 to bit 6 or bit 1 selects LSB-first framing, which starts with the next frame; it then reads back with both bits 6 and 1 set (0x5A).
- R6: Writing 1 to bit 5 or bit 2 of address 0x00 returns every register, shadow and live, to its reset value one cycle later. The bit clears itself and reads 0.
- R7: Address 0x01 reads the `CHIP_ID` parameter. Address 0x02 reads 0x08 when `SPEED_FAST` is 1 and 0x00 otherwise. Writes to both are ignored.
- R8: Writes to 0x08, 0x09 and 0x14 change only the shadow copy, which reads back at once. Writing 1 to bit 0 of 0xFF copies all shadows into the live copies in one cycle. 0xFF reads 0.
- R9: Live 0x08 bits 1:0 give `pwr_state`: code 1 is full power-down (`pwr_state` 1), code 2 is standby (`pwr_state` 2), codes 0 and 3 are normal (`pwr_state` 0). `pin_pwdn` high forces `pwr_state` to 1 one cycle later.
- R10: Live 0x09 bit 0 drives `stab_en` (reset 1). Live 0x14 bits 1:0 drive `out_fmt` (reset 0; 0 offset binary, 1 two's complement, 2 Gray).
- R11: Unused bits of mapped registers read 0 and hold 0 whatever is written. Unmapped addresses, including any with address bits 12:8 non-zero, read 0x00 and ignore writes.
- R12: If chip-select is low when reset ends, the port stays disabled until the next reset and `sdio_oe` stays low. `stab_en` then follows `sdio_in`, `out_fmt` is 1 while `sclk` is high and 0 while it is low, and `pwr_state` follows only `pin_pwdn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csb | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock, or format strap in strap mode |
| sdio_in | input | 1 | Serial data in, or stabilizer strap in strap mode |
| sdio_out | output | 1 | Serial read data |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| pin_pwdn | input | 1 | Power-down pin, overrides the register |
| pwr_state | output | 2 | 0 normal, 1 full power-down, 2 standby |
| stab_en | output | 1 | Duty-cycle stabilizer enable |
| out_fmt | output | 2 | Output data format code |

## Verification
The bench goes after the address step direction in multi-byte and streaming frames, in both bit orders. A design that stepped the wrong way, or that took the new bit order in the middle of a frame, would return the neighbouring register's byte. It clocks extra bytes after short length codes: a block that counted bytes wrongly would overwrite the next register. It checks that outputs stay put after shadow writes and move only on commit. A design without a real shadow copy, or one that a soft reset left partly set, would show the new values too early or keep stale live settings. Strap mode is entered through a second reset, to catch a port that still answers frames or that ignores the pin levels.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W  = 13;
  localparam int BYTE_W  = 8;
  localparam int INSTR_W = 16;
  localparam int HI_W    = ADDR_W - BYTE_W;

  localparam logic [7:0] RA_CFG   = 8'h00;
  localparam logic [7:0] RA_ID    = 8'h01;
  localparam logic [7:0] RA_GRADE = 8'h02;
  localparam logic [7:0] RA_PWR   = 8'h08;
  localparam logic [7:0] RA_STAB  = 8'h09;
  localparam logic [7:0] RA_FMT   = 8'h14;
  localparam logic [7:0] RA_XFER  = 8'hFF;

  localparam logic [7:0] CFG_FIXED = 8'h18;

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_t;

  localparam logic [1:0] PS_RUN  = 2'd0;
  localparam logic [1:0] PS_OFF  = 2'd1;
  localparam logic [1:0] PS_STBY = 2'd2;

  function automatic logic [1:0] pwr_decode(input logic [1:0] code);
    case (code)
      2'd1:    pwr_decode = PS_OFF;
      2'd2:    pwr_decode = PS_STBY;
      default: pwr_decode = PS_RUN;
    endcase
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff <= RST_VAL;
        else        ff <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff <= {STAGES{RST_VAL}};
        else        ff <= {ff[STAGES-2:0], d};
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/scp_frame.sv
module scp_frame
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              lsb_mode,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  logic sclk_d, csb_d;
  logic rise, fall, start;
  phase_t ph;
  logic [3:0] bcnt;
  logic [INSTR_W-1:0] isr;
  logic [BYTE_W-1:0]  dsr, osr;
  logic rw_q, stream_q, lsb_q, load_pend;
  logic [1:0] left_q;

  assign rise  = sclk_s & ~sclk_d & ~csb_s;
  assign fall  = ~sclk_s & sclk_d & ~csb_s;
  assign start = ~csb_s & csb_d;

  logic [INSTR_W-1:0] isr_nx;
  logic [BYTE_W-1:0]  dsr_nx;
  logic [ADDR_W-1:0]  step_addr;
  assign isr_nx    = lsb_q ? {sdi_s, isr[INSTR_W-1:1]} : {isr[INSTR_W-2:0], sdi_s};
  assign dsr_nx    = lsb_q ? {sdi_s, dsr[BYTE_W-1:1]}  : {dsr[BYTE_W-2:0], sdi_s};
  assign step_addr = lsb_q ? cur_addr + 13'd1 : cur_addr - 13'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0; csb_d <= 1'b1;
      ph <= PH_INSTR; bcnt <= '0; isr <= '0; dsr <= '0; osr <= '0;
      rw_q <= 1'b0; stream_q <= 1'b0; lsb_q <= 1'b0; load_pend <= 1'b0;
      left_q <= '0; cur_addr <= '0; wr_en <= 1'b0; wr_addr <= '0;
      wr_data <= '0; sdo <= 1'b0; sdo_oe <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      csb_d  <= csb_s;
      wr_en  <= 1'b0;
      if (csb_s) begin
        ph <= PH_INSTR; bcnt <= '0; sdo_oe <= 1'b0; load_pend <= 1'b0;
      end else begin
        if (start) lsb_q <= lsb_mode;
        if (load_pend) begin
          osr <= rd_data;
          load_pend <= 1'b0;
        end
        if (rise) begin
          case (ph)
            PH_INSTR: begin
              isr  <= isr_nx;
              bcnt <= bcnt + 4'd1;
              if (bcnt == 4'd15) begin
                rw_q      <= isr_nx[15];
                stream_q  <= &isr_nx[14:13];
                left_q    <= isr_nx[14:13];
                cur_addr  <= isr_nx[ADDR_W-1:0];
                ph        <= PH_DATA;
                bcnt      <= '0;
                load_pend <= isr_nx[15];
              end
            end
            PH_DATA: begin
              dsr  <= dsr_nx;
              bcnt <= bcnt + 4'd1;
              if (bcnt == 4'd7) begin
                bcnt <= '0;
                if (!rw_q) begin
                  wr_en   <= 1'b1;
                  wr_addr <= cur_addr;
                  wr_data <= dsr_nx;
                end
                cur_addr <= step_addr;
                if (!stream_q && left_q == 2'd0) begin
                  ph     <= PH_DONE;
                  sdo_oe <= 1'b0;
                end else begin
                  if (!stream_q) left_q <= left_q - 2'd1;
                  load_pend <= rw_q;
                end
              end
            end
            default: ;
          endcase
        end
        if (fall && ph == PH_DATA && rw_q) begin
          sdo    <= lsb_q ? osr[0] : osr[BYTE_W-1];
          osr    <= lsb_q ? (osr >> 1) : (osr << 1);
          sdo_oe <= 1'b1;
        end
      end
    end
  end

  // R4: the data line is driven only in read frames
  a_r4_oe_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> rw_q);
  // R4: raising chip-select releases the line
  a_r4_release_on_csb: assert property (@(posedge clk) disable iff (!rst_n)
    csb_s |=> !sdo_oe);
  // R1: register writes come only from write frames
  a_r1_write_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rw_q);
  // R2: a finished frame writes nothing more
  a_r2_done_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DONE) |=> !wr_en);
endmodule

// File: rtl/scp_regs.sv
module scp_regs
  import spi_cfg_pkg::*;
#(
  parameter logic [7:0] CHIP_ID    = 8'h4B,
  parameter bit         SPEED_FAST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              lsb_mode,
  output logic [1:0]        act_pwr,
  output logic              act_stab,
  output logic [1:0]        act_fmt
);
  logic srst_q;
  logic [1:0] mst_pwr, mst_fmt;
  logic mst_stab;

  logic wr_hit, xfer_go;
  logic [7:0] wa;
  assign wa      = wr_addr[7:0];
  assign wr_hit  = wr_en && (wr_addr[ADDR_W-1:BYTE_W] == '0);
  assign xfer_go = wr_hit && (wa == RA_XFER) && wr_data[0] && !srst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0; lsb_mode <= 1'b0;
      mst_pwr <= 2'd0; mst_stab <= 1'b1; mst_fmt <= 2'd0;
      act_pwr <= 2'd0; act_stab <= 1'b1; act_fmt <= 2'd0;
    end else if (srst_q) begin
      srst_q <= 1'b0; lsb_mode <= 1'b0;
      mst_pwr <= 2'd0; mst_stab <= 1'b1; mst_fmt <= 2'd0;
      act_pwr <= 2'd0; act_stab <= 1'b1; act_fmt <= 2'd0;
    end else if (wr_hit) begin
      case (wa)
        RA_CFG: begin
          lsb_mode <= wr_data[6] | wr_data[1];
          srst_q   <= wr_data[5] | wr_data[2];
        end
        RA_PWR:  mst_pwr  <= wr_data[1:0];
        RA_STAB: mst_stab <= wr_data[0];
        RA_FMT:  mst_fmt  <= wr_data[1:0];
        RA_XFER: if (wr_data[0]) begin
          act_pwr  <= mst_pwr;
          act_stab <= mst_stab;
          act_fmt  <= mst_fmt;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[ADDR_W-1:BYTE_W] == '0) begin
      case (rd_addr[7:0])
        RA_CFG:   rd_data = CFG_FIXED | {1'b0, lsb_mode, 4'b0, lsb_mode, 1'b0};
        RA_ID:    rd_data = CHIP_ID;
        RA_GRADE: rd_data = {4'b0, SPEED_FAST, 3'b0};
        RA_PWR:   rd_data = {6'b0, mst_pwr};
        RA_STAB:  rd_data = {7'b0, mst_stab};
        RA_FMT:   rd_data = {6'b0, mst_fmt};
        default:  rd_data = '0;
      endcase
    end
  end

  // R8: commit copies every shadow into the live set
  a_r8_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> (act_pwr == $past(mst_pwr)) && (act_stab == $past(mst_stab))
                && (act_fmt == $past(mst_fmt)));
  // R8: without commit or soft reset the live set holds
  a_r8_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_go && !srst_q) |=> $stable({act_pwr, act_stab, act_fmt}));
  // R6: soft reset restores defaults and clears itself
  a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q && !lsb_mode && mst_pwr == 2'd0 && mst_stab
               && act_pwr == 2'd0 && act_stab && act_fmt == 2'd0);
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter logic [7:0] CHIP_ID     = 8'h4B,
  parameter bit         SPEED_FAST  = 1'b1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csb,
  input  logic       sclk,
  input  logic       sdio_in,
  output logic       sdio_out,
  output logic       sdio_oe,
  input  logic       pin_pwdn,
  output logic [1:0] pwr_state,
  output logic       stab_en,
  output logic [1:0] out_fmt
);
  localparam int SET_W = $clog2(SYNC_STAGES + 2);

  logic csb_s, sclk_s, sdio_s;
  scp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csb
    (.clk(clk), .rst_n(rst_n), .d(csb), .q(csb_s));
  scp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk
    (.clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
  scp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdio
    (.clk(clk), .rst_n(rst_n), .d(sdio_in), .q(sdio_s));

  logic [SET_W-1:0] settle;
  logic strap_q, ready;
  assign ready = (settle == SET_W'(SYNC_STAGES + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle  <= '0;
      strap_q <= 1'b0;
    end else if (!ready) begin
      settle <= settle + 1'b1;
      if (settle == SET_W'(SYNC_STAGES)) strap_q <= ~csb_s;
    end
  end

  logic csb_eff;
  assign csb_eff = csb_s | strap_q | ~ready;

  logic [ADDR_W-1:0] cur_addr, wr_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic wr_en, lsb_mode, act_stab;
  logic [1:0] act_pwr, act_fmt;

  scp_frame u_frame (
    .clk(clk), .rst_n(rst_n), .csb_s(csb_eff), .sclk_s(sclk_s), .sdi_s(sdio_s),
    .lsb_mode(lsb_mode), .rd_data(rd_data), .cur_addr(cur_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdio_out), .sdo_oe(sdio_oe));

  scp_regs #(.CHIP_ID(CHIP_ID), .SPEED_FAST(SPEED_FAST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(cur_addr), .rd_data(rd_data),
    .lsb_mode(lsb_mode), .act_pwr(act_pwr), .act_stab(act_stab),
    .act_fmt(act_fmt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_state <= PS_RUN;
      stab_en   <= 1'b1;
      out_fmt   <= 2'd0;
    end else if (strap_q) begin
      pwr_state <= pin_pwdn ? PS_OFF : PS_RUN;
      stab_en   <= sdio_s;
      out_fmt   <= {1'b0, sclk_s};
    end else begin
      pwr_state <= pin_pwdn ? PS_OFF : pwr_decode(act_pwr);
      stab_en   <= act_stab;
      out_fmt   <= act_fmt;
    end
  end

  // R9: the pin overrides any register setting
  a_r9_pin_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pwdn |=> pwr_state == PS_OFF);
  // R12: strap mode keeps the serial port quiet
  a_r12_strap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    strap_q |-> !wr_en && !sdio_oe);
endmodule

// File: tb/sim_spi_cfg_port.sv
module sim_spi_cfg_port;
  localparam int CLK_NS = 10;
  localparam int HALF   = 6;
  localparam logic [7:0] ID = 8'h4B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csb = 1'b1, sclk = 1'b0, sdio_in = 1'b0, pin_pwdn = 1'b0;
  logic sdio_out, sdio_oe, stab_en;
  logic [1:0] pwr_state, out_fmt;

  spi_cfg_port u0 (.clk(clk), .rst_n(rst_n), .csb(csb), .sclk(sclk),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .pin_pwdn(pin_pwdn), .pwr_state(pwr_state), .stab_en(stab_en),
    .out_fmt(out_fmt));

  always #(CLK_NS/2) clk = ~clk;

  int nchk = 0, nfail = 0, oe_bad = 0, oe_miss = 0;
  bit lsb_b = 0, rd_frame = 0, strap_phase = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic [1:0] m_pwr, m_fmt, a_pwr, a_fmt;
  logic m_stab, a_stab;

  always @(negedge clk) if (sdio_oe && !rd_frame) oe_bad++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit samp, output logic got);
    sdio_in = b;
    ticks(HALF);
    got = sdio_out;
    if (samp && !sdio_oe) oe_miss++;
    sclk = 1'b1;
    ticks(HALF);
    sclk = 1'b0;
  endtask

  task automatic frame(input bit rd, input logic [1:0] w, input logic [12:0] a,
                       input int nby);
    logic [15:0] iw;
    logic g;
    iw = {rd, w, a};
    rd_frame = rd;
    csb = 1'b0;
    ticks(HALF);
    for (int i = 0; i < 16; i++) send_bit(lsb_b ? iw[i] : iw[15-i], 1'b0, g);
    for (int k = 0; k < nby; k++)
      for (int j = 0; j < 8; j++) begin
        int idx;
        idx = lsb_b ? j : 7 - j;
        send_bit(wbuf[k][idx], rd && (w == 2'd3 || k <= int'(w)), g);
        rbuf[k][idx] = g;
      end
    ticks(HALF);
    csb = 1'b1;
    ticks(12);
    rd_frame = 1'b0;
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] v);
    wbuf[0] = v;
    frame(1'b0, 2'd0, a, 1);
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] v);
    wbuf[0] = 8'h00;
    frame(1'b1, 2'd0, a, 1);
    v = rbuf[0];
  endtask

  function automatic logic [1:0] exp_pwr(input logic [1:0] c);
    return (c == 2'd1) ? 2'd1 : (c == 2'd2) ? 2'd2 : 2'd0;
  endfunction

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed));
    ticks(4);
    rst_n = 1'b1;
    ticks(8);
    // R10 reset state
    chk("R10 reset pwr_state", pwr_state, 2'd0);
    chk("R10 reset stab_en", stab_en, 1'b1);
    chk("R10 reset out_fmt", out_fmt, 2'd0);
    // R1 R5 R7 basic reads
    rd1(13'h000, v); chk("R5 cfg default", v, 8'h18);
    rd1(13'h001, v); chk("R1 R7 chip id", v, ID);
    rd1(13'h002, v); chk("R7 speed grade", v, 8'h08);
    wr1(13'h001, 8'h00); rd1(13'h001, v); chk("R7 id write ignored", v, ID);
    wr1(13'h002, 8'hFF); rd1(13'h002, v); chk("R7 grade write ignored", v, 8'h08);
    // R8 R9 shadow and commit
    wr1(13'h008, 8'h02);
    chk("R8 no change before commit", pwr_state, 2'd0);
    rd1(13'h008, v); chk("R8 shadow readback", v, 8'h02);
    wr1(13'h0FF, 8'h01);
    chk("R9 standby after commit", pwr_state, 2'd2);
    rd1(13'h0FF, v); chk("R8 commit reads zero", v, 8'h00);
    wr1(13'h008, 8'h03); wr1(13'h0FF, 8'h01);
    chk("R9 code 3 normal", pwr_state, 2'd0);
    wr1(13'h008, 8'h01); wr1(13'h0FF, 8'h01);
    chk("R9 code 1 power-down", pwr_state, 2'd1);
    wr1(13'h008, 8'h00); wr1(13'h0FF, 8'h01);
    pin_pwdn = 1'b1; ticks(3);
    chk("R9 pin override", pwr_state, 2'd1);
    pin_pwdn = 1'b0; ticks(3);
    chk("R9 pin release", pwr_state, 2'd0);
    // R11 open bits and unmapped space
    wr1(13'h009, 8'hFE); rd1(13'h009, v); chk("R11 stab open bits", v, 8'h00);
    wr1(13'h014, 8'hFE); rd1(13'h014, v); chk("R11 fmt open bits", v, 8'h02);
    wr1(13'h005, 8'h77); rd1(13'h005, v); chk("R11 unmapped reads 0", v, 8'h00);
    wr1(13'h108, 8'h03); rd1(13'h008, v); chk("R11 high address ignored", v, 8'h00);
    // R2 R3 multi-byte MSB-first, address steps down
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    frame(1'b0, 2'd1, 13'h009, 2);
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    frame(1'b1, 2'd1, 13'h009, 2);
    chk("R2 two-byte read first", rbuf[0], 8'h01);
    chk("R3 two-byte read stepped down", rbuf[1], 8'h02);
    wbuf[0] = 8'h00; wbuf[1] = 8'h03;
    frame(1'b0, 2'd0, 13'h009, 2);
    rd1(13'h009, v); chk("R2 single byte written", v, 8'h00);
    rd1(13'h008, v); chk("R2 extra byte ignored", v, 8'h02);
    wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
    frame(1'b1, 2'd3, 13'h002, 3);
    chk("R3 stream msb byte0", rbuf[0], 8'h08);
    chk("R3 stream msb byte1", rbuf[1], ID);
    chk("R3 stream msb byte2", rbuf[2], 8'h18);
    // R5 LSB-first, R3 stepping up
    wr1(13'h000, 8'h40);
    lsb_b = 1;
    rd1(13'h000, v); chk("R5 lsb mirrored readback", v, 8'h5A);
    wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
    frame(1'b1, 2'd3, 13'h000, 3);
    chk("R3 stream lsb byte0", rbuf[0], 8'h5A);
    chk("R3 stream lsb byte1", rbuf[1], ID);
    chk("R3 stream lsb byte2", rbuf[2], 8'h08);
    wbuf[0] = 8'h01; wbuf[1] = 8'h00;
    frame(1'b0, 2'd1, 13'h008, 2);
    rd1(13'h008, v); chk("R3 lsb write byte0", v, 8'h01);
    rd1(13'h009, v); chk("R3 lsb write stepped up", v, 8'h00);
    wr1(13'h0FF, 8'h01);
    chk("R8 commit in lsb frame", pwr_state, 2'd1);
    chk("R8 stab committed", stab_en, 1'b0);
    // R6 soft reset
    wr1(13'h000, 8'h04);
    lsb_b = 0;
    chk("R6 live pwr reset", pwr_state, 2'd0);
    chk("R6 live stab reset", stab_en, 1'b1);
    chk("R6 live fmt reset", out_fmt, 2'd0);
    rd1(13'h000, v); chk("R6 cfg back to default", v, 8'h18);
    rd1(13'h008, v); chk("R6 shadow pwr reset", v, 8'h00);
    rd1(13'h014, v); chk("R6 shadow fmt reset", v, 8'h00);
    // R8 R10 random traffic against a model
    m_pwr = 0; m_fmt = 0; m_stab = 1; a_pwr = 0; a_fmt = 0; a_stab = 1;
    for (int it = 0; it < 40; it++) begin
      int sel;
      logic [7:0] val;
      sel = $urandom % 3;
      val = 8'($urandom);
      case (sel)
        0: begin wr1(13'h008, val); m_pwr = val[1:0]; rd1(13'h008, v);
                 chk("R8 rand pwr shadow", v, {6'b0, m_pwr}); end
        1: begin wr1(13'h009, val); m_stab = val[0]; rd1(13'h009, v);
                 chk("R8 rand stab shadow", v, {7'b0, m_stab}); end
        default: begin wr1(13'h014, val); m_fmt = val[1:0]; rd1(13'h014, v);
                 chk("R8 rand fmt shadow", v, {6'b0, m_fmt}); end
      endcase
      chk("R8 rand live holds", {pwr_state, stab_en, out_fmt},
          {exp_pwr(a_pwr), a_stab, a_fmt});
      if ($urandom % 2) begin
        wr1(13'h0FF, 8'h01);
        a_pwr = m_pwr; a_stab = m_stab; a_fmt = m_fmt;
        chk("R9 R10 rand commit", {pwr_state, stab_en, out_fmt},
            {exp_pwr(a_pwr), a_stab, a_fmt});
      end
    end
    // R4 line direction
    chk("R4 no drive outside reads", oe_bad, 0);
    chk("R4 drive during read data", oe_miss, 0);
    // R12 strap mode
    rst_n = 1'b0; csb = 1'b0; sdio_in = 1'b1; sclk = 1'b1;
    ticks(4);
    rst_n = 1'b1;
    ticks(10);
    chk("R12 strap stab high", stab_en, 1'b1);
    chk("R12 strap twos complement", out_fmt, 2'd1);
    sdio_in = 1'b0; sclk = 1'b0; ticks(6);
    chk("R12 strap stab low", stab_en, 1'b0);
    chk("R12 strap offset binary", out_fmt, 2'd0);
    pin_pwdn = 1'b1; ticks(4);
    chk("R12 strap pin power-down", pwr_state, 2'd1);
    pin_pwdn = 1'b0;
    for (int i = 0; i < 24; i++) begin
      sdio_in = 1'b1; sclk = ~sclk; ticks(HALF);
    end
    chk("R12 port disabled no drive", oe_bad, 0);
    summary();
  end
endmodule